// File: doc/BRIEF.md
# Per-Module Clock Powerdown Controller

This block decides, for every function module of a multi-function peripheral device, whether that module's clock runs. Software programs a small register bank. Each module has a two-bit method field that selects one of three methods:

- **Running**: the clock runs.
- **Direct stop**: the clock is removed whatever the module is doing.
- **Automatic stop**: the clock is removed only after the module has reported idle for a programmable number of cycles.

A single global bit stops every module at once. With the default parameters there are three modules: the floppy controller, the serial port and the parallel port.

Each module drives an idle flag and a wake flag into the block. A wake flag marks a register access or a wake request. For each module the block returns a clock enable and a gated clock. The enable changes only on the falling edge of the source clock, so the gated clock never carries a shortened high pulse. A read-only status register shows which modules are stopped at present.

Top module: `pd_clk_ctrl`

## Requirements
- R1: After reset every clock enable is high, the status register reads 0, the method register reads 0, and every idle-threshold register reads RST_THRESH (default 4).
- R2: The method register is at address 0. Module i uses bits [2i+1:2i], and the value 00 means running. A field change is acted on at the rising edge after the write edge. Changing one module's field leaves the other modules unaffected.
- R3: The method code 01 stops the module: the enable falls at the falling edge after the first rising edge that sees the code. Idle and wake inputs have no effect on this.
- R4: The method code 10 is automatic. Module i's threshold register is at address 3+i. The enable drops at the falling edge after T consecutive rising edges that see idle high and wake low, where T = max(threshold, 1).
- R5: In automatic mode, a cycle with idle low during the count restarts the count from zero.
- R6: In automatic mode, a wake on a stopped module makes it leave the stopped state at the next rising edge. The enable is high again at the following falling edge, and counting starts afresh.
- R7: The method code 11 is reserved and behaves as running.
- R8: Bit 0 of address 1 is a global stop. While it is set, every module behaves as method 01, whatever its field and inputs. Clearing the bit returns each module to its own field.
- R9: Writing 00 to the field of a stopped module restarts its clock one rising edge later.
- R10: Address 2 reads bit i as 1 while module i is stopped. Writes to address 2 change nothing.
- R11: Each enable changes only at falling edges of clk. Each gated clock equals clk AND its enable.
- R12: A wake in the same cycle as threshold expiry wins, and the clock keeps running.
- R13: Reads of unmapped addresses (3+N_MOD and above) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data, combinational from addr |
| mod_idle | input | N_MOD | Per-module idle report |
| mod_wake | input | N_MOD | Per-module activity or wake request |
| mod_clk_en | output | N_MOD | Per-module clock enable, updated on falling edges |
| mod_gclk | output | N_MOD | Per-module gated clock |

## Verification
Idle-count expiry and a wake request can reach a module's state machine at the same rising edge. Wake must win, so the clock stays enabled (R12). The bench provokes this case directly with a threshold of 1. It drives the wake on the very edge that would complete the count, and then checks that the enable remains high at the next falling edge and drops one idle edge later. Random stimulus with frequent idle cycles and occasional wakes makes the same collision happen many more times. A cycle-level model in the bench judges every one of those cycles.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_DIRECT = 2'b01,
        MODE_AUTO   = 2'b10,
        MODE_RSVD   = 2'b11
    } pd_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_COUNT = 2'd1,
        ST_GATED = 2'd2
    } pd_state_e;

    localparam int ADDR_MODE = 0;
    localparam int ADDR_CTRL = 1;
    localparam int ADDR_STAT = 2;
    localparam int ADDR_THR0 = 3;

    // Global stop overrides the field; the reserved code falls back to running.
    function automatic pd_mode_e resolve_mode(input logic [1:0] field, input logic force_dn);
        pd_mode_e m;
        if (force_dn) begin
            m = MODE_DIRECT;
        end else begin
            case (field)
                2'b01:   m = MODE_DIRECT;
                2'b10:   m = MODE_AUTO;
                default: m = MODE_RUN;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/pd_regs.sv
module pd_regs
    import pd_pkg::*;
#(
    parameter int          N_MOD      = 3,
    parameter int          AW         = 3,
    parameter int          DW         = 8,
    parameter int          TW         = 8,
    parameter int unsigned RST_THRESH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic [N_MOD-1:0]      gated,
    output logic [2*N_MOD-1:0]    mode_q,
    output logic                  glob_q,
    output logic [N_MOD*TW-1:0]   thr_q,
    output logic [DW-1:0]         rd_data
);

    localparam int MW = 2 * N_MOD;

    typedef struct packed {
        logic [MW-1:0]       mode;
        logic                glob;
        logic [N_MOD*TW-1:0] thr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == AW'(ADDR_MODE)) r_d.mode = wdata[MW-1:0];
            if (addr == AW'(ADDR_CTRL)) r_d.glob = wdata[0];
            for (int i = 0; i < N_MOD; i++) begin
                if (addr == AW'(ADDR_THR0 + i)) r_d.thr[i*TW +: TW] = wdata[TW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= '0;
            r_q.glob <= 1'b0;
            r_q.thr  <= {N_MOD{TW'(RST_THRESH)}};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == AW'(ADDR_MODE)) rd_data[MW-1:0]    = r_q.mode;
        if (addr == AW'(ADDR_CTRL)) rd_data[0]         = r_q.glob;
        if (addr == AW'(ADDR_STAT)) rd_data[N_MOD-1:0] = gated;
        for (int i = 0; i < N_MOD; i++) begin
            if (addr == AW'(ADDR_THR0 + i)) rd_data[TW-1:0] = r_q.thr[i*TW +: TW];
        end
    end

    assign mode_q = r_q.mode;
    assign glob_q = r_q.glob;
    assign thr_q  = r_q.thr;

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pd_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_field,
    input  logic          force_dn,
    input  logic          idle,
    input  logic          wake,
    input  logic [TW-1:0] thresh,
    output logic          gated
);

    typedef struct packed {
        pd_state_e     st;
        logic [TW-1:0] cnt;
    } fsm_t;

    fsm_t     s_d, s_q;
    pd_mode_e eff;
    logic [TW:0] cnt_inc;

    always_comb begin
        eff     = resolve_mode(mode_field, force_dn);
        cnt_inc = {1'b0, s_q.cnt} + 1'b1;
        s_d     = s_q;
        case (eff)
            MODE_DIRECT: begin
                s_d.st  = ST_GATED;
                s_d.cnt = '0;
            end
            MODE_AUTO: begin
                if (wake || !idle) begin
                    // activity wins over any pending expiry
                    s_d.st  = ST_COUNT;
                    s_d.cnt = '0;
                end else if (s_q.st != ST_GATED) begin
                    if (cnt_inc >= {1'b0, thresh}) begin
                        s_d.st  = ST_GATED;
                        s_d.cnt = '0;
                    end else begin
                        s_d.st  = ST_COUNT;
                        s_d.cnt = cnt_inc[TW-1:0];
                    end
                end
            end
            default: begin
                s_d.st  = ST_RUN;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_RUN;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gated = (s_q.st == ST_GATED);

endmodule

// File: rtl/pd_gate.sv
module pd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic clk_en,
    output logic gclk
);

    logic en_d, en_q;

    always_comb en_d = en_req;

    // Enable moves only while clk is low, so a high phase is never cut short.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_d;
    end

    assign clk_en = en_q;
    assign gclk   = clk & en_q;

endmodule

// File: rtl/pd_clk_ctrl.sv
module pd_clk_ctrl
    import pd_pkg::*;
#(
    parameter int          N_MOD      = 3,
    parameter int          AW         = 3,
    parameter int          DW         = 8,
    parameter int          TW         = 8,
    parameter int unsigned RST_THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data,
    input  logic [N_MOD-1:0] mod_idle,
    input  logic [N_MOD-1:0] mod_wake,
    output logic [N_MOD-1:0] mod_clk_en,
    output logic [N_MOD-1:0] mod_gclk
);

    logic [2*N_MOD-1:0]  mode_q;
    logic                glob_q;
    logic [N_MOD*TW-1:0] thr_q;
    logic [N_MOD-1:0]    gated;

    pd_regs #(
        .N_MOD(N_MOD), .AW(AW), .DW(DW), .TW(TW), .RST_THRESH(RST_THRESH)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .gated  (gated),
        .mode_q (mode_q),
        .glob_q (glob_q),
        .thr_q  (thr_q),
        .rd_data(rd_data)
    );

    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
        pd_fsm #(.TW(TW)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_field(mode_q[2*i +: 2]),
            .force_dn  (glob_q),
            .idle      (mod_idle[i]),
            .wake      (mod_wake[i]),
            .thresh    (thr_q[i*TW +: TW]),
            .gated     (gated[i])
        );

        pd_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .en_req(!gated[i]),
            .clk_en(mod_clk_en[i]),
            .gclk  (mod_gclk[i])
        );
    end

endmodule

// File: rtl/pd_clk_ctrl_chk.sv
module pd_clk_ctrl_chk #(
    parameter int N_MOD = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*N_MOD-1:0] mode_q,
    input logic               glob_q,
    input logic [N_MOD-1:0]   mod_wake,
    input logic [N_MOD-1:0]   gated,
    input logic [N_MOD-1:0]   clk_en
);

    // R8: the global stop forces every module down one edge later
    p_global_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        glob_q |=> (&gated));

    for (genvar i = 0; i < N_MOD; i++) begin : g_chk
        // R3
        p_direct_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b01) |=> gated[i]);
        // R9
        p_run_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b00 && !glob_q) |=> !gated[i]);
        // R7
        p_reserved_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b11 && !glob_q) |=> !gated[i]);
        // R6 and R12
        p_wake_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b10 && !glob_q && mod_wake[i]) |=> !gated[i]);
        // R11: enable at a rising edge reflects the state captured one falling edge earlier
        p_enable_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[i] == !gated[i]);
    end

endmodule

bind pd_clk_ctrl pd_clk_ctrl_chk #(.N_MOD(N_MOD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .glob_q  (glob_q),
    .mod_wake(mod_wake),
    .gated   (gated),
    .clk_en  (mod_clk_en)
);

// File: tb/tb_pd_clk_ctrl.sv
`timescale 1ns/1ps
module tb_pd_clk_ctrl;

    localparam int N  = 3;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int TW = 8;
    localparam int RST_T = 4;
    localparam logic [N-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  mod_idle = '1;
    logic [N-1:0]  mod_wake = '0;
    logic [N-1:0]  mod_clk_en;
    logic [N-1:0]  mod_gclk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pd_clk_ctrl #(.N_MOD(N), .AW(AW), .DW(DW), .TW(TW), .RST_THRESH(RST_T)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .mod_idle(mod_idle), .mod_wake(mod_wake),
        .mod_clk_en(mod_clk_en), .mod_gclk(mod_gclk)
    );

    // bench model: state 0 running, 1 counting, 2 stopped
    logic [2*N-1:0] m_mode;
    logic           m_glob;
    int             m_thr[N];
    int             m_st[N];
    int             m_cnt[N];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_mode = '0;
        m_glob = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_thr[i] = RST_T; m_st[i] = 0; m_cnt[i] = 0;
        end
    endtask

    function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        int ai;
        v  = '0;
        ai = int'(a);
        if (ai == 0) v[2*N-1:0] = m_mode;
        else if (ai == 1) v[0] = m_glob;
        else if (ai == 2) begin
            for (int i = 0; i < N; i++) v[i] = (m_st[i] == 2);
        end else if (ai >= 3 && ai < 3 + N) v = DW'(m_thr[ai-3]);
        return v;
    endfunction

    function automatic string tag_addr(input logic [AW-1:0] a);
        int ai;
        ai = int'(a);
        if (ai == 0) return "R2";
        if (ai == 1) return "R8";
        if (ai == 2) return "R10";
        if (ai < 3 + N) return "R4";
        return "R13";
    endfunction

    function automatic string tag_mode(input int i);
        logic [1:0] f;
        f = m_mode[2*i +: 2];
        if (m_glob) return "R8";
        if (f == 2'b01) return "R3";
        if (f == 2'b11) return "R7";
        if (f == 2'b00) return "R9";
        return "R4";
    endfunction

    task automatic m_edge(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [N-1:0] idl, input logic [N-1:0] wk);
        for (int i = 0; i < N; i++) begin
            logic [1:0] f;
            int eff;
            f   = m_mode[2*i +: 2];
            eff = m_glob ? 1 : ((f == 2'b11) ? 0 : int'(f));
            if (eff == 0) begin
                m_st[i] = 0; m_cnt[i] = 0;
            end else if (eff == 1) begin
                m_st[i] = 2; m_cnt[i] = 0;
            end else if (wk[i] || !idl[i]) begin
                m_st[i] = 1; m_cnt[i] = 0;
            end else if (m_st[i] != 2) begin
                if (m_cnt[i] + 1 >= m_thr[i]) begin
                    m_st[i] = 2; m_cnt[i] = 0;
                end else begin
                    m_st[i] = 1; m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
        if (we) begin
            if (int'(a) == 0) m_mode = d[2*N-1:0];
            else if (int'(a) == 1) m_glob = d[0];
            else if (int'(a) >= 3 && int'(a) < 3 + N) m_thr[int'(a)-3] = int'(d);
        end
    endtask

    // One clock cycle; called and returning just after a falling edge.
    task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [N-1:0] idl, input logic [N-1:0] wk);
        wr_en = we; addr = a; wdata = d; mod_idle = idl; mod_wake = wk;
        #0.5;
        if (!we) chk(tag_addr(a), rd_data, m_read(a), "read data");
        @(posedge clk);
        m_edge(we, a, d, idl, wk);
        #1;
        for (int i = 0; i < N; i++) chk("R11", mod_gclk[i], mod_clk_en[i], "gated clock high phase");
        @(negedge clk);
        #1;
        for (int i = 0; i < N; i++) chk(tag_mode(i), mod_clk_en[i], (m_st[i] != 2), "clock enable");
    endtask

    task automatic idle_cyc(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, AW'(0), '0, ALL, '0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        m_reset();
        #12;
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1", mod_clk_en, ALL, "enables after reset");
        addr = AW'(2); #0.5; chk("R1", rd_data, 0, "status after reset");
        addr = AW'(3); #0.5; chk("R1", rd_data, RST_T, "threshold after reset");
        addr = AW'(0); #0.5; chk("R1", rd_data, 0, "method after reset");

        // R4 automatic count with threshold 3
        cyc(1'b1, AW'(3), 8'd3, ALL, '0);
        cyc(1'b1, AW'(0), 8'h02, ALL, '0);
        idle_cyc(2);
        chk("R4", mod_clk_en[0], 1, "still running before expiry");
        idle_cyc(1);
        chk("R4", mod_clk_en[0], 0, "stopped at expiry");
        chk("R2", mod_clk_en[2:1], 2'b11, "other modules unaffected");

        // R10 status reads and ignored write
        addr = AW'(2); #0.5; chk("R10", rd_data, 1, "status bit 0");
        cyc(1'b1, AW'(2), 8'hFF, ALL, '0);
        addr = AW'(2); #0.5; chk("R10", rd_data, 1, "status after write attempt");

        // R6 wake restarts a stopped module
        cyc(1'b0, AW'(0), '0, ALL, 3'b001);
        chk("R6", mod_clk_en[0], 1, "enable after wake");

        // R5 activity restarts the count
        idle_cyc(2);
        cyc(1'b0, AW'(0), '0, 3'b110, '0);
        idle_cyc(2);
        chk("R5", mod_clk_en[0], 1, "count restarted by activity");
        idle_cyc(1);
        chk("R5", mod_clk_en[0], 0, "stopped after fresh count");

        // R12 wake collides with expiry at threshold 1
        cyc(1'b1, AW'(3), 8'd1, ALL, '0);
        cyc(1'b0, AW'(0), '0, ALL, 3'b001);
        cyc(1'b0, AW'(0), '0, ALL, 3'b001);
        chk("R12", mod_clk_en[0], 1, "wake wins over expiry");
        idle_cyc(1);
        chk("R12", mod_clk_en[0], 0, "expiry after wake drops");

        // R7 reserved code on module 1
        cyc(1'b1, AW'(0), 8'h0E, ALL, '0);
        idle_cyc(4);
        chk("R7", mod_clk_en[1], 1, "reserved code keeps running");

        // R3 direct stop despite activity
        cyc(1'b1, AW'(0), 8'h06, 3'b000, 3'b010);
        cyc(1'b0, AW'(0), '0, 3'b000, 3'b010);
        chk("R3", mod_clk_en[1], 0, "direct stop ignores activity");

        // R9 back to running
        cyc(1'b1, AW'(0), 8'h02, ALL, '0);
        cyc(1'b0, AW'(0), '0, ALL, '0);
        chk("R9", mod_clk_en[1], 1, "running after field cleared");

        // R8 global stop overrides wake
        cyc(1'b1, AW'(1), 8'h01, 3'b000, ALL);
        cyc(1'b0, AW'(0), '0, 3'b000, ALL);
        chk("R8", mod_clk_en, 0, "global stop");
        cyc(1'b1, AW'(1), 8'h00, 3'b000, ALL);
        cyc(1'b0, AW'(0), '0, 3'b000, ALL);
        chk("R8", mod_clk_en, ALL, "global stop released");

        // R13 unmapped reads
        addr = AW'(7); #0.5; chk("R13", rd_data, 0, "unmapped address 7");
        addr = AW'(6); #0.5; chk("R13", rd_data, 0, "unmapped address 6");

        // constrained random
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 4000; k++) begin
            logic we;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [N-1:0] idl, wk;
            we = ($urandom_range(0, 5) == 0);
            a  = AW'($urandom_range(0, 7));
            if (int'(a) == 1)      d = DW'($urandom_range(0, 7) == 0);
            else if (int'(a) >= 3) d = DW'($urandom_range(0, 5));
            else                   d = DW'($urandom);
            for (int i = 0; i < N; i++) begin
                idl[i] = ($urandom_range(0, 9) != 0);
                wk[i]  = ($urandom_range(0, 19) == 0);
            end
            cyc(we, a, d, idl, wk);
        end

        done = 1;
        summary();
    end

endmodule